// File: doc/BRIEF.md
# Reloading Periodic Tick Timer

A down-counting period timer for a system tick. Software writes a period length into a divider register, then issues a load operation that copies the divider into the counter without starting it, and then a run operation that starts the countdown. At the default 100 MHz base clock, a divider of 1,000,000 gives one expiry every 1,000,000 cycles, which is a 100 Hz tick.

Each time the period ends, the counter reloads from the divider and a raw pending flag is raised. An enable mask gates the pending flag onto the interrupt line. Writing a one to the acknowledge input clears the flag. The counter value can be read back live, so software can work out the time elapsed in the current period as (divider − count) × 10 ns.

The divider may be rewritten while the timer is running. The countdown in progress finishes with its old length, and the new value takes effect at the next reload.

Top module: `tick_timer`

## Requirements
- R1: After reset the count is 0, the raw pending flag is 0, the mask is 0, the interrupt is 0 and the timer is stopped.
- R2: An operation write with code 2'b01 (load) copies the divider register into the count and stops the timer. The count then holds its value.
- R3: An operation write with code 2'b10 (run) starts the timer. While it runs, a count above 1 drops by one on each clock.
- R4: While the timer runs, a clock edge that sees a count of 1 or 0 reloads the count from the divider and sets the raw pending flag on that same edge. The period is therefore exactly divider cycles for a divider of 1 or more.
- R5: An operation write with code 2'b00 or 2'b11 (stop) freezes the count at its current value. A later run resumes the countdown from that value. An operation write takes priority over counting on the same edge.
- R6: The interrupt output (masked status) equals the raw pending flag when the mask bit, written through mask_we/mask_in, is 1, and is 0 when the mask bit is 0.
- R7: A write to the acknowledge input with ack_in = 1 clears the raw pending flag. A write with ack_in = 0 leaves it unchanged.
- R8: When an acknowledge and an expiry fall on the same edge, the raw pending flag stays 1.
- R9: Writing the divider while the timer runs does not change the countdown in progress. The next reload uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_we | input | 1 | Divider register write strobe |
| div_in | input | CW | New divider value |
| op_we | input | 1 | Operation write strobe |
| op_in | input | 2 | Operation: 00/11 stop, 01 load, 10 run |
| mask_we | input | 1 | Mask write strobe |
| mask_in | input | 1 | New mask bit |
| ack_we | input | 1 | Acknowledge write strobe |
| ack_in | input | 1 | Acknowledge bit, 1 clears the pending flag |
| count_out | output | CW | Live counter value |
| raw_pend | output | 1 | Unmasked pending flag |
| irq | output | 1 | Masked interrupt status |

## Verification
The hardest case to reach is an acknowledge that arrives on the exact edge where the counter expires. The bench loads a short divider, counts the running edges from the run command, and checks that the count reads 1 at the negative edge before it raises the acknowledge. A second awkward case is a divider rewrite in the middle of a period. The bench places it a known number of edges after run, then confirms that the old countdown continues and that the following reload lands on the new value.

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          div_we,
  input  logic [CW-1:0] div_in,
  input  logic          op_we,
  input  logic [1:0]    op_in,
  input  logic          mask_we,
  input  logic          mask_in,
  input  logic          ack_we,
  input  logic          ack_in,
  output logic [CW-1:0] count_out,
  output logic          raw_pend,
  output logic          irq
);
  localparam logic [1:0] OP_LOAD = 2'b01;
  localparam logic [1:0] OP_RUN  = 2'b10;
  localparam logic [CW-1:0] ONE  = CW'(1);

  logic [CW-1:0] div_q, cnt_q;
  logic          run_q, mask_q, pend_q;
  logic          expire;

  assign expire = run_q && !op_we && (cnt_q <= ONE);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      div_q <= '0;
    else if (div_we) div_q <= div_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else if (op_we) begin
      run_q <= (op_in == OP_RUN);
      if (op_in == OP_LOAD) cnt_q <= div_q;
    end else if (expire) begin
      cnt_q <= div_q;
    end else if (run_q) begin
      cnt_q <= cnt_q - ONE;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       mask_q <= 1'b0;
    else if (mask_we) mask_q <= mask_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= expire | (pend_q & ~(ack_we & ack_in));

  assign count_out = cnt_q;
  assign raw_pend  = pend_q;
  assign irq       = pend_q & mask_q;
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_we,
  input logic [1:0]    op_in,
  input logic          ack_we,
  input logic          ack_in,
  input logic [CW-1:0] div_q,
  input logic [CW-1:0] count_out,
  input logic          run_q,
  input logic          raw_pend
);
  logic at_end;
  assign at_end = run_q && !op_we && (count_out <= CW'(1));

  // R2
  load_copies_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_we && op_in == 2'b01) |=> (count_out == $past(div_q)) && !run_q);

  // R3
  decrement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !op_we && count_out > CW'(1)) |=> count_out == $past(count_out) - CW'(1));

  // R4
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    at_end |=> (count_out == $past(div_q)) && raw_pend);

  // R5
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !op_we) |=> $stable(count_out));

  // R7
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && ack_in && !at_end) |=> !raw_pend);

  // R8
  expiry_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_we && ack_in && at_end) |=> raw_pend);
endmodule

bind tick_timer tick_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_we(op_we), .op_in(op_in),
  .ack_we(ack_we), .ack_in(ack_in), .div_q(div_q),
  .count_out(count_out), .run_q(run_q), .raw_pend(raw_pend)
);

// File: tb/tick_timer_test.sv
module tick_timer_test;
  localparam int CW = 32;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic div_we = 0, op_we = 0, mask_we = 0, mask_in = 0, ack_we = 0, ack_in = 0;
  logic [CW-1:0] div_in = '0;
  logic [1:0] op_in = '0;
  logic [CW-1:0] count_out;
  logic raw_pend, irq;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  tick_timer #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .div_we(div_we), .div_in(div_in),
    .op_we(op_we), .op_in(op_in), .mask_we(mask_we), .mask_in(mask_in),
    .ack_we(ack_we), .ack_in(ack_in), .count_out(count_out),
    .raw_pend(raw_pend), .irq(irq)
  );

  localparam int NV = 6;
  localparam int VD[NV] = '{10, 10, 5, 1, 0, 100};
  localparam int VN[NV] = '{3, 10, 7, 4, 4, 0};
  localparam int VE[NV] = '{7, 10, 3, 1, 0, 100};

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_div(input int v);
    div_we = 1; div_in = CW'(v);
    @(negedge clk); div_we = 0;
  endtask

  task automatic do_op(input logic [1:0] c);
    op_we = 1; op_in = c;
    @(negedge clk); op_we = 0;
  endtask

  task automatic do_ack(input logic b);
    ack_we = 1; ack_in = b;
    @(negedge clk); ack_we = 0; ack_in = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 count", count_out, 0);
    chk("R1 pend", raw_pend, 0);
    chk("R1 irq", irq, 0);
    rst_n = 1;
    @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R1 stopped count", count_out, 0);

    for (int i = 0; i < NV; i++) begin
      wr_div(VD[i]);
      do_op(2'b01);
      do_op(2'b10);
      repeat (VN[i]) @(negedge clk);
      do_op(2'b00);
      chk($sformatf("R3/R4 vector %0d", i), count_out, VE[i]);
    end

    // R2: load does not start
    wr_div(20);
    do_op(2'b01);
    repeat (5) @(negedge clk);
    chk("R2 load holds", count_out, 20);

    // R5: stop freezes, run resumes
    do_op(2'b10);
    repeat (4) @(negedge clk);
    do_op(2'b11);
    chk("R5 stop value", count_out, 16);
    repeat (6) @(negedge clk);
    chk("R5 frozen", count_out, 16);
    do_op(2'b10);
    repeat (2) @(negedge clk);
    chk("R5 resume", count_out, 14);
    do_op(2'b00);

    // R6 / R7
    do_ack(1);
    chk("R7 cleared", raw_pend, 0);
    wr_div(3);
    do_op(2'b01);
    do_op(2'b10);
    repeat (3) @(negedge clk);
    do_op(2'b00);
    chk("R4 pend set", raw_pend, 1);
    chk("R4 reload", count_out, 3);
    chk("R6 masked off", irq, 0);
    mask_we = 1; mask_in = 1; @(negedge clk); mask_we = 0;
    chk("R6 masked on", irq, 1);
    do_ack(0);
    chk("R7 ack zero ignored", raw_pend, 1);
    do_ack(1);
    chk("R7 ack clears", raw_pend, 0);
    chk("R6 irq follows", irq, 0);

    // R8: ack on expiry edge, pending stays
    wr_div(4);
    do_op(2'b01);
    do_op(2'b10);
    repeat (3) @(negedge clk);
    chk("R8 setup count", count_out, 1);
    do_ack(1);
    chk("R8 expiry wins", raw_pend, 1);
    chk("R8 reload", count_out, 4);
    do_op(2'b00);

    // R9: divider rewrite mid-period
    wr_div(6);
    do_op(2'b01);
    do_op(2'b10);
    repeat (2) @(negedge clk);
    chk("R9 pre", count_out, 4);
    wr_div(3);
    chk("R9 continues", count_out, 3);
    repeat (2) @(negedge clk);
    chk("R9 old period end", count_out, 1);
    @(negedge clk);
    chk("R9 new divider", count_out, 3);
    do_op(2'b00);

    finish_run();
  end
endmodule